// File: doc/BRIEF.md
# Road-Matching Hit Filter

This block takes a stream of 11-bit cluster centroids and tests each one against a table of track roads. A road is a window of two 11-bit bounds. Its table index is the track number. A centroid lies inside a road when it is at or above the lower bound and strictly below the upper bound. For every road whose window holds the centroid, the block emits one 32-bit hit word. Each hit word carries the track number, the event's sequence and readout-group identifiers, the centroid itself, and two small fields copied from the incoming word.

Roads and a road-count register are loaded through a simple write port between events. An event header latches the sequence and group identifiers, and an end-of-event strobe clears them. After a centroid is accepted, the block walks through the loaded roads one per cycle, starting at road 0. It stalls whenever the hit output is held back, and it refuses a new centroid until the walk is finished. An all-zero centroid or an all-zero bound never produces a match.

Top module: `road_hit_filter`

## Requirements
- R1: After reset `cen_ready` is 1 and `hit_valid` is 0. The road count, the identifiers and all road bounds are zero, so a centroid accepted before any load produces no hit.
- R2: No hit is produced when the centroid is zero, or when the road's lower bound or upper bound is zero.
- R3: A road matches when lower <= centroid < upper, compared as unsigned numbers. A centroid equal to the upper bound does not match.
- R4: The hit word is {track[31:26], area[25:24], seq[23:16], group[15:13], centroid[12:2], precision[1:0]}.
- R5: Roads are tested in ascending index order from 0 to count-1, and one hit is emitted for each match. Roads at an index at or above the count are never tested.
- R6: `hdr_valid` latches `hdr_seq` and `hdr_grp`, and the values hold until `evt_end` clears both to zero. When both strobes arrive in the same cycle, the header wins.
- R7: While `hit_valid` is 1 and `hit_ready` is 0, the hit word holds steady and the scan does not advance.
- R8: `cen_ready` drops in the cycle after a centroid is accepted when the count is non-zero. It stays low for exactly count cycles when the output is not stalled. A `cen_valid` that arrives while `cen_ready` is low is ignored. With a count of zero, `cen_ready` stays 1.
- R9: A count write larger than N_ROADS (64) is stored as N_ROADS.
- R10: In the 17-bit centroid word, bits 14..13 (area) and 1..0 (precision) pass unchanged into the hit, bits 12..2 are the centroid, and bits 16..15 (kind) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| road_we | input | 1 | Write one road entry |
| road_idx | input | 6 | Road index (track number) to write |
| road_lo | input | 11 | Lower bound, inclusive |
| road_hi | input | 11 | Upper bound, exclusive |
| cnt_we | input | 1 | Write the road count |
| cnt_val | input | 7 | Road count to write (clamped to N_ROADS) |
| hdr_valid | input | 1 | Event header strobe |
| hdr_seq | input | 8 | Event sequence identifier |
| hdr_grp | input | 3 | Readout-group identifier |
| evt_end | input | 1 | End-of-event strobe, clears identifiers |
| cen_valid | input | 1 | Centroid word offered |
| cen_ready | output | 1 | Centroid can be accepted |
| cen_word | input | 17 | Centroid word {kind, area, centroid, precision} |
| hit_valid | output | 1 | Hit word available |
| hit_ready | input | 1 | Consumer takes the hit word |
| hit_word | output | 32 | Formatted hit |

## Verification
The road for index j is tested at the j+1-th clock edge after the accepting edge, so a matching hit appears one cycle after that test. `cen_ready` returns after count edges when there is no stall. The bench drives inputs just after a rising edge and samples on the falling edge. It counts the falling edges on which `cen_ready` is low, and it records hits on falling edges where both `hit_valid` and `hit_ready` are 1. Each run waits until the block is idle with no pending hit before it compares the recorded words and their order against a model built from the requirements.

// File: rtl/rhf_pkg.sv
// Package: shared field widths and word layouts for the road-matching hit filter.
// Assumes the 6-bit track field bounds the road table at 64 entries.
package rhf_pkg;
    localparam int POS_W  = 11;
    localparam int TRK_W  = 6;
    localparam int SEQ_W  = 8;
    localparam int GRP_W  = 3;

    // Incoming centroid word, 17 bits.
    typedef struct packed {
        logic [1:0]       kind;
        logic [1:0]       area;
        logic [POS_W-1:0] pos;
        logic [1:0]       prec;
    } cen_word_t;

    // Outgoing hit word, 32 bits.
    typedef struct packed {
        logic [TRK_W-1:0] trk;
        logic [1:0]       area;
        logic [SEQ_W-1:0] seq;
        logic [GRP_W-1:0] grp;
        logic [POS_W-1:0] pos;
        logic [1:0]       prec;
    } hit_word_t;
endpackage

// File: rtl/rhf_road_store.sv
// Road table: N_ROADS pairs of bounds plus a clamped count register.
// Assumes writes happen between events; the read port is a plain mux on rd_idx.
module rhf_road_store
    import rhf_pkg::*;
#(
    parameter int N_ROADS = 64,
    localparam int CNT_W  = TRK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             road_we,
    input  logic [TRK_W-1:0] road_idx,
    input  logic [POS_W-1:0] road_lo,
    input  logic [POS_W-1:0] road_hi,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [TRK_W-1:0] rd_idx,
    output logic [POS_W-1:0] rd_lo,
    output logic [POS_W-1:0] rd_hi,
    output logic [CNT_W-1:0] cnt_q
);
    logic [POS_W-1:0] lo_q [N_ROADS];
    logic [POS_W-1:0] hi_q [N_ROADS];

    for (genvar g = 0; g < N_ROADS; g++) begin : g_road
        // Holds one road's bounds; cleared by reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end else if (road_we && (road_idx == TRK_W'(g))) begin
                lo_q[g] <= road_lo;
                hi_q[g] <= road_hi;
            end
        end
    end

    // Road count register, clamped to the table size.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= (cnt_val > CNT_W'(N_ROADS)) ? CNT_W'(N_ROADS) : cnt_val;
    end

    // Read mux; an index past the table reads as an empty road.
    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        if (int'(rd_idx) < N_ROADS) begin
            rd_lo = lo_q[rd_idx];
            rd_hi = hi_q[rd_idx];
        end
    end
endmodule

// File: rtl/rhf_match.sv
// Window test: lower <= pos < upper, unsigned, with any all-zero operand rejected.
// Purely combinational.
module rhf_match
    import rhf_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] lo,
    input  logic [POS_W-1:0] hi,
    output logic             hit
);
    logic above_lo, below_hi, operands_ok;

    // Bound tests and zero guard.
    always_comb begin
        operands_ok = (pos != '0) && (lo != '0) && (hi != '0);
        below_hi    = hi > pos;
        above_lo    = pos >= lo;
        hit         = operands_ok && below_hi && above_lo;
    end
endmodule

// File: rtl/rhf_scan_ctrl.sv
// Scan sequencer: accepts one centroid, then steps a road index from 0 to count-1.
// Assumes one road test per cycle; a step happens only when the output slot is free.
module rhf_scan_ctrl
    import rhf_pkg::*;
#(
    localparam int CNT_W = TRK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen_valid,
    input  cen_word_t        cen_word,
    output logic             cen_ready,
    input  logic [CNT_W-1:0] cnt,
    input  logic             out_free,
    input  logic             match,
    output logic [TRK_W-1:0] idx,
    output cen_word_t        cen_q,
    output logic             load
);
    typedef enum logic {S_IDLE, S_SCAN} state_t;
    state_t state;
    logic   step, last;

    // Step and end-of-scan decode.
    always_comb begin
        cen_ready = (state == S_IDLE);
        step      = (state == S_SCAN) && out_free;
        last      = ({1'b0, idx} == (cnt - CNT_W'(1)));
        load      = step && match;
    end

    // State, index and centroid capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            cen_q <= '0;
        end else if (state == S_IDLE) begin
            if (cen_valid && (cnt != '0)) begin
                state <= S_SCAN;
                idx   <= '0;
                cen_q <= cen_word;
            end
        end else if (step) begin
            if (last)
                state <= S_IDLE;
            else
                idx <= idx + TRK_W'(1);
        end
    end
endmodule

// File: rtl/rhf_hit_fmt.sv
// Event identifier latch and one-entry hit output register.
// Assumes load is asserted only when the slot is free (out_free).
module rhf_hit_fmt
    import rhf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [SEQ_W-1:0] hdr_seq,
    input  logic [GRP_W-1:0] hdr_grp,
    input  logic             evt_end,
    input  logic             load,
    input  logic [TRK_W-1:0] trk,
    input  cen_word_t        cen_q,
    input  logic             hit_ready,
    output logic             hit_valid,
    output logic [31:0]      hit_word,
    output logic             out_free
);
    logic [SEQ_W-1:0] seq_q;
    logic [GRP_W-1:0] grp_q;
    hit_word_t        word_q;

    assign out_free = !hit_valid || hit_ready;
    assign hit_word = word_q;

    // Identifier latch: header wins over end-of-event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
            grp_q <= '0;
        end else if (hdr_valid) begin
            seq_q <= hdr_seq;
            grp_q <= hdr_grp;
        end else if (evt_end) begin
            seq_q <= '0;
            grp_q <= '0;
        end
    end

    // Output slot: load a formatted hit or drain on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            word_q    <= '0;
        end else if (load) begin
            hit_valid   <= 1'b1;
            word_q.trk  <= trk;
            word_q.area <= cen_q.area;
            word_q.seq  <= seq_q;
            word_q.grp  <= grp_q;
            word_q.pos  <= cen_q.pos;
            word_q.prec <= cen_q.prec;
        end else if (hit_ready) begin
            hit_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/road_hit_filter.sv
// Top: road-matching hit filter. Wires the road table, the sequencer, the window
// test and the hit formatter. Assumes roads and count are stable during a scan.
module road_hit_filter
    import rhf_pkg::*;
#(
    parameter int N_ROADS = 64,
    localparam int CNT_W  = TRK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             road_we,
    input  logic [TRK_W-1:0] road_idx,
    input  logic [POS_W-1:0] road_lo,
    input  logic [POS_W-1:0] road_hi,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             hdr_valid,
    input  logic [SEQ_W-1:0] hdr_seq,
    input  logic [GRP_W-1:0] hdr_grp,
    input  logic             evt_end,
    input  logic             cen_valid,
    output logic             cen_ready,
    input  logic [16:0]      cen_word,
    output logic             hit_valid,
    input  logic             hit_ready,
    output logic [31:0]      hit_word
);
    logic [CNT_W-1:0] cnt_q;
    logic [TRK_W-1:0] idx;
    logic [POS_W-1:0] rd_lo, rd_hi;
    logic             match, load, out_free;
    cen_word_t        cen_in, cen_q;
    logic [1:0]       unused_kind;

    assign cen_in      = cen_word;
    assign unused_kind = cen_q.kind;

    rhf_road_store #(.N_ROADS(N_ROADS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .road_we(road_we), .road_idx(road_idx), .road_lo(road_lo), .road_hi(road_hi),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .rd_idx(idx), .rd_lo(rd_lo), .rd_hi(rd_hi), .cnt_q(cnt_q)
    );

    rhf_scan_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cen_valid(cen_valid), .cen_word(cen_in), .cen_ready(cen_ready),
        .cnt(cnt_q), .out_free(out_free), .match(match),
        .idx(idx), .cen_q(cen_q), .load(load)
    );

    rhf_match u_match (
        .pos(cen_q.pos), .lo(rd_lo), .hi(rd_hi), .hit(match)
    );

    rhf_hit_fmt u_fmt (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_seq(hdr_seq), .hdr_grp(hdr_grp), .evt_end(evt_end),
        .load(load), .trk(idx), .cen_q(cen_q),
        .hit_ready(hit_ready), .hit_valid(hit_valid), .hit_word(hit_word),
        .out_free(out_free)
    );
endmodule

// File: rtl/rhf_checker.sv
// Checker: temporal properties of the hit filter, bound to every instance of the top.
module rhf_checker #(
    parameter int N_ROADS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cen_valid,
    input logic        cen_ready,
    input logic        hit_valid,
    input logic        hit_ready,
    input logic [31:0] hit_word,
    input logic [6:0]  cnt_q
);
    // R7: a stalled hit stays put.
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !hit_ready |=> hit_valid && $stable(hit_word));

    // R2: no hit ever carries a zero centroid.
    a_r2_nonzero_pos: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> hit_word[12:2] != 11'd0);

    // R5: the track number stays below the loaded count.
    a_r5_track_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> {1'b0, hit_word[31:26]} < cnt_q);

    // R8: an accepted centroid with roads loaded makes the block busy.
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cen_valid && cen_ready && (cnt_q != 7'd0) |=> !cen_ready);

    // R9: the count never exceeds the table size.
    a_r9_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 7'(N_ROADS));
endmodule

bind road_hit_filter rhf_checker #(.N_ROADS(N_ROADS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cen_valid(cen_valid), .cen_ready(cen_ready),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_word(hit_word), .cnt_q(cnt_q)
);

// File: tb/road_hit_filter_tb_top.sv
// Directed bench: one task per scenario, a model built from the requirements.
module road_hit_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        road_we = 1'b0;
    logic [5:0]  road_idx = '0;
    logic [10:0] road_lo = '0, road_hi = '0;
    logic        cnt_we = 1'b0;
    logic [6:0]  cnt_val = '0;
    logic        hdr_valid = 1'b0;
    logic [7:0]  hdr_seq = '0;
    logic [2:0]  hdr_grp = '0;
    logic        evt_end = 1'b0;
    logic        cen_valid = 1'b0;
    logic        cen_ready;
    logic [16:0] cen_word = '0;
    logic        hit_valid;
    logic        hit_ready = 1'b1;
    logic [31:0] hit_word;

    int n_checks = 0, n_fail = 0;
    bit bp_mode = 1'b0;
    int cyc = 0;

    // Bench model state.
    logic [10:0] m_lo [NR];
    logic [10:0] m_hi [NR];
    int          m_cnt = 0;
    logic [7:0]  m_seq = '0;
    logic [2:0]  m_grp = '0;

    logic [31:0] cap [256];
    int          ncap = 0;
    logic [31:0] expw [NR];
    int          nexp = 0;

    road_hit_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .road_we(road_we), .road_idx(road_idx), .road_lo(road_lo), .road_hi(road_hi),
        .cnt_we(cnt_we), .cnt_val(cnt_val),
        .hdr_valid(hdr_valid), .hdr_seq(hdr_seq), .hdr_grp(hdr_grp), .evt_end(evt_end),
        .cen_valid(cen_valid), .cen_ready(cen_ready), .cen_word(cen_word),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_word(hit_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Output ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 hit_ready = bp_mode ? ((cyc % 3) == 2) : 1'b1;
    end

    // Hit capture and stall-stability check on falling edges.
    logic        prev_stall = 1'b0;
    logic [31:0] prev_word = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(hit_valid && (hit_word == prev_word), "R7 stalled hit held",
                    hit_word, prev_word);
            end
            if (hit_valid && hit_ready && ncap < 256) begin
                cap[ncap] = hit_word;
                ncap++;
            end
            prev_stall = hit_valid && !hit_ready;
            prev_word  = hit_word;
        end
    end

    function automatic logic [31:0] pack(input int trk, input logic [16:0] w);
        return {6'(trk), w[14:13], m_seq, m_grp, w[12:2], w[1:0]};
    endfunction

    // Builds the expected hit list from the window rule and the model table.
    task automatic model(input logic [16:0] w);
        int eff;
        logic [10:0] p;
        eff  = (m_cnt > NR) ? NR : m_cnt;
        p    = w[12:2];
        nexp = 0;
        for (int i = 0; i < eff; i++) begin
            if (p != 0 && m_lo[i] != 0 && m_hi[i] != 0 && p >= m_lo[i] && p < m_hi[i]) begin
                expw[nexp] = pack(i, w);
                nexp++;
            end
        end
    endtask

    task automatic wr_road(input int i, input int lo, input int hi);
        @(posedge clk); #1;
        road_we = 1'b1; road_idx = 6'(i); road_lo = 11'(lo); road_hi = 11'(hi);
        @(posedge clk); #1;
        road_we = 1'b0;
        m_lo[i] = 11'(lo); m_hi[i] = 11'(hi);
    endtask

    task automatic wr_cnt(input int c);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_val = 7'(c);
        @(posedge clk); #1;
        cnt_we = 1'b0;
        m_cnt = c;
    endtask

    task automatic strobe(input bit hv, input bit ee, input int s, input int g);
        @(posedge clk); #1;
        hdr_valid = hv; evt_end = ee; hdr_seq = 8'(s); hdr_grp = 3'(g);
        @(posedge clk); #1;
        hdr_valid = 1'b0; evt_end = 1'b0;
        if (hv) begin m_seq = 8'(s); m_grp = 3'(g); end
        else if (ee) begin m_seq = '0; m_grp = '0; end
    endtask

    function automatic logic [16:0] cw(input int kind, input int area, input int pos, input int prec);
        return {2'(kind), 2'(area), 11'(pos), 2'(prec)};
    endfunction

    // Sends one centroid, optionally keeps offering another while busy, compares hits.
    task automatic run_cen(input string tag, input logic [16:0] w, input int extra,
                           input logic [16:0] alt, output int busy);
        int guard;
        model(w);
        ncap = 0;
        busy = 0;
        @(posedge clk); #1;
        cen_valid = 1'b1; cen_word = w;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!cen_ready && guard < 1000);
        @(posedge clk); #1;
        cen_word = alt;
        cen_valid = (extra > 0);
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            if (!cen_ready) busy++;
            @(posedge clk); #1;
        end
        cen_valid = 1'b0;
        guard = 0;
        do begin
            @(negedge clk);
            if (!cen_ready) busy++;
            guard++;
        end while (!(cen_ready && !hit_valid) && guard < 2000);
        chk(ncap == nexp, {tag, " hit count"}, ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++)
            chk(cap[i] == expw[i], {tag, " hit word"}, cap[i], expw[i]);
    endtask

    task automatic t_reset();
        int b;
        @(negedge clk);
        chk(cen_ready == 1'b1, "R1 ready after reset", cen_ready, 1);
        chk(hit_valid == 1'b0, "R1 no hit after reset", hit_valid, 0);
        run_cen("R1 empty table", cw(0, 1, 50, 1), 0, '0, b);
        chk(b == 0, "R8 count zero stays ready", b, 0);
    endtask

    task automatic t_basic();
        int b;
        wr_road(0, 10, 20);
        wr_road(1, 100, 400);
        wr_road(2, 500, 600);
        wr_road(3, 250, 260);
        wr_road(4, 200, 255);
        wr_cnt(5);
        strobe(1, 0, 'hA5, 5);
        run_cen("R4 R5 two roads", cw(0, 2, 255, 1), 0, '0, b);
        chk(ncap == 2 && cap[0] == {6'd1, 2'd2, 8'hA5, 3'd5, 11'd255, 2'd1},
            "R4 explicit layout", cap[0], {6'd1, 2'd2, 8'hA5, 3'd5, 11'd255, 2'd1});
        chk(b == 5, "R8 busy cycles equal count", b, 5);
    endtask

    task automatic t_bounds();
        int b;
        run_cen("R3 equal lower", cw(0, 0, 100, 0), 0, '0, b);
        run_cen("R3 just below upper", cw(0, 3, 399, 2), 0, '0, b);
        run_cen("R3 equal upper", cw(0, 1, 400, 1), 0, '0, b);
        chk(ncap == 0, "R3 upper exclusive", ncap, 0);
        run_cen("R10 kind ignored area prec kept", cw(3, 1, 15, 3), 0, '0, b);
        chk(ncap == 1 && cap[0][1:0] == 2'd3 && cap[0][25:24] == 2'd1,
            "R10 pass-through", cap[0], {6'd0, 2'd1, 8'hA5, 3'd5, 11'd15, 2'd3});
    endtask

    task automatic t_zero();
        int b;
        run_cen("R2 zero centroid", cw(0, 1, 0, 1), 0, '0, b);
        chk(ncap == 0, "R2 zero centroid no hit", ncap, 0);
        wr_road(5, 0, 2000);
        wr_cnt(6);
        run_cen("R2 zero lower bound", cw(0, 1, 1000, 1), 0, '0, b);
        chk(ncap == 0, "R2 zero bound no hit", ncap, 0);
    endtask

    task automatic t_count();
        int b;
        wr_road(6, 900, 1100);
        run_cen("R5 road beyond count", cw(0, 1, 1000, 1), 0, '0, b);
        chk(ncap == 0, "R5 road at count ignored", ncap, 0);
        wr_cnt(100);
        run_cen("R9 clamped count", cw(0, 1, 1000, 1), 0, '0, b);
        chk(b == NR, "R9 scan length clamped", b, NR);
    endtask

    task automatic t_busy();
        int b;
        wr_cnt(5);
        run_cen("R8 offer while busy", cw(0, 1, 15, 1), 3, cw(0, 1, 255, 1), b);
        chk(ncap == 1, "R8 busy offer ignored", ncap, 1);
    endtask

    task automatic t_backpressure();
        int b;
        bp_mode = 1'b1;
        run_cen("R7 backpressure", cw(0, 2, 255, 1), 0, '0, b);
        bp_mode = 1'b0;
        chk(b > 5, "R7 scan stalls", b, 6);
    endtask

    task automatic t_header();
        int b;
        strobe(0, 1, 0, 0);
        run_cen("R6 cleared ids", cw(0, 1, 15, 1), 0, '0, b);
        chk(ncap == 1 && cap[0][23:13] == 11'd0, "R6 end clears ids", cap[0][23:13], 0);
        strobe(1, 1, 'h3C, 2);
        run_cen("R6 header wins", cw(0, 1, 15, 1), 0, '0, b);
        chk(ncap == 1 && cap[0][23:13] == {8'h3C, 3'd2}, "R6 header over end",
            cap[0][23:13], {8'h3C, 3'd2});
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_bounds();
        t_zero();
        t_count();
        t_busy();
        t_backpressure();
        t_header();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule